// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block posts interrupt events into a set of circular event queues kept in a word-addressed memory, one queue for each priority level. An upstream source presents an event strobe with a priority and a logical interrupt number. The block turns each event into a single 32-bit memory write into the next free slot of the chosen queue, and it pulses a notification toward the thread context for every event it posts.

The queues have no head or tail registers that the consumer reads. Each written word carries a generation flag. The producer writes the flag as 1 during its first lap through a queue and inverts it each time that queue's write index wraps back to slot zero. A consumer keeps its own read index and expected flag. It treats a slot as new only when the flag in the slot matches the value it expects.

The memory address is the priority concatenated with the slot index, so each queue occupies its own contiguous 1024-word region. Arbitration for the memory, address translation and queue configuration are handled outside this block.

Top module: `evq_writer`

## Requirements
- R1: Bits 30:0 of every written word hold the logical interrupt number, zero-extended from 10 bits.
- R2: The word address of a write is {priority[2:0], slot index[9:0]}: priority in bits 12:10 and slot index in bits 9:0.
- R3: Each post advances only the selected queue's slot index, by one. The indices of the other seven queues do not change.
- R4: Bit 31 of a written word is the selected queue's generation flag. The flag inverts when that queue's index wraps from 1023 back to 0, so it applies from the 1025th post onward and returns to 1 after 2048 posts.
- R5: After a synchronous reset, every queue's slot index is 0 and its generation flag is 1. While reset is asserted, mem_we and notify stay low.
- R6: Every write comes with a one-cycle notify pulse that carries the same priority, even when earlier entries are still unconsumed.
- R7: A write appears exactly one clock after the cycle in which ev_valid is high. No write appears after a cycle in which ev_valid is low.
- R8: Events presented on consecutive cycles, to the same queue or to different queues, each produce their own write, in order, with no event lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_prio | input | 3 | Priority, which selects the queue |
| ev_lirq | input | 10 | Logical interrupt number |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 13 | Word address {priority, slot index} |
| mem_wdata | output | 32 | Entry word {generation flag, logical interrupt number} |
| notify | output | 1 | Notification pulse to the thread context |
| notify_prio | output | 3 | Priority of the notified queue |

## Verification
The bench drives 2050 posts into a single queue, so the generation flag is seen going to 0 at the first wrap and back to 1 at the second. A design that inverted the flag one slot early or late, or never inverted it, would leave words that a consumer reads as stale or takes as new when they are not. Posts to different queues on consecutive cycles check that one queue's index never moves on another queue's event, and a reset in the middle of the run checks that every queue restarts at slot 0 with the flag set. A dropped notify pulse, or a notify sent with the wrong priority, shows up as a mismatch against the expected item in the scoreboard.

// File: rtl/evq_pkg.sv
package evq_pkg;

  localparam int unsigned ENTRY_W  = 32;
  localparam int unsigned GEN_POS  = ENTRY_W - 1;
  localparam int unsigned PAYLD_W  = ENTRY_W - 1;

  typedef struct packed {
    logic               gen;
    logic [PAYLD_W-1:0] lirq;
  } evq_entry_t;

  // Build one queue word: the flag and the payload travel in the same write.
  function automatic evq_entry_t pack_entry(input logic gen, input logic [PAYLD_W-1:0] lirq);
    evq_entry_t e;
    e.gen  = gen;
    e.lirq = lirq;
    return e;
  endfunction

  // Flag written after a slot is used: it flips only when the slot was the last one.
  function automatic logic next_gen(input logic gen, input logic at_last);
    return at_last ? ~gen : gen;
  endfunction

endpackage

// File: rtl/evq_slot.sv
// Per-queue producer state: the write index and the generation flag.
module evq_slot #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post,
  output logic [IDX_W-1:0] idx,
  output logic             gen,
  output logic             wrap
);
  import evq_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic at_last;

  assign at_last = (idx == LAST_IDX);
  assign wrap    = post && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      gen <= 1'b1;
    end else if (post) begin
      idx <= idx + 1'b1;
      gen <= next_gen(gen, at_last);
    end
  end

endmodule

// File: rtl/evq_pick.sv
// Selects the state of the addressed queue.
module evq_pick #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned IDX_W    = 10,
  localparam int unsigned PRIO_W  = $clog2(NUM_PRIO)
) (
  input  logic [NUM_PRIO-1:0][IDX_W-1:0] idx_vec,
  input  logic [NUM_PRIO-1:0]            gen_vec,
  input  logic [PRIO_W-1:0]              sel,
  output logic [IDX_W-1:0]               idx,
  output logic                           gen
);

  always_comb begin
    idx = '0;
    gen = 1'b0;
    for (int q = 0; q < NUM_PRIO; q++) begin
      if (sel == PRIO_W'(q)) begin
        idx = idx_vec[q];
        gen = gen_vec[q];
      end
    end
  end

endmodule

// File: rtl/evq_emit.sv
// Output register stage: the write port and the notification.
module evq_emit #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fire,
  input  logic [ADDR_W-1:0]           addr_in,
  input  evq_pkg::evq_entry_t         entry_in,
  input  logic [PRIO_W-1:0]           prio_in,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [evq_pkg::ENTRY_W-1:0] mem_wdata,
  output logic                        notify,
  output logic [PRIO_W-1:0]           notify_prio
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0;
      notify <= 1'b0;
    end else begin
      mem_we <= fire;
      notify <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      mem_addr    <= addr_in;
      mem_wdata   <= entry_in;
      notify_prio <= prio_in;
    end
  end

endmodule

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned LIRQ_W   = 10,
  localparam int unsigned PRIO_W  = $clog2(NUM_PRIO),
  localparam int unsigned ADDR_W  = PRIO_W + IDX_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ev_valid,
  input  logic [PRIO_W-1:0]           ev_prio,
  input  logic [LIRQ_W-1:0]           ev_lirq,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [evq_pkg::ENTRY_W-1:0] mem_wdata,
  output logic                        notify,
  output logic [PRIO_W-1:0]           notify_prio
);
  import evq_pkg::*;

  // Internal events, named for the checker.
  logic [NUM_PRIO-1:0]            post_hit;
  logic [NUM_PRIO-1:0]            wrap_hit;
  logic [NUM_PRIO-1:0][IDX_W-1:0] idx_vec;
  logic [NUM_PRIO-1:0]            gen_vec;
  logic [IDX_W-1:0]               idx_sel;
  logic                           gen_sel;
  evq_entry_t                     entry;
  logic [ADDR_W-1:0]              addr;

  for (genvar q = 0; q < NUM_PRIO; q++) begin : g_queue
    assign post_hit[q] = ev_valid && (ev_prio == PRIO_W'(q));

    evq_slot #(.IDX_W(IDX_W)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .post (post_hit[q]),
      .idx  (idx_vec[q]),
      .gen  (gen_vec[q]),
      .wrap (wrap_hit[q])
    );
  end

  evq_pick #(.NUM_PRIO(NUM_PRIO), .IDX_W(IDX_W)) u_pick (
    .idx_vec (idx_vec),
    .gen_vec (gen_vec),
    .sel     (ev_prio),
    .idx     (idx_sel),
    .gen     (gen_sel)
  );

  assign entry = pack_entry(gen_sel, {{(PAYLD_W-LIRQ_W){1'b0}}, ev_lirq});
  assign addr  = {ev_prio, idx_sel};

  evq_emit #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) u_emit (
    .clk         (clk),
    .rst         (rst),
    .fire        (ev_valid),
    .addr_in     (addr),
    .entry_in    (entry),
    .prio_in     (ev_prio),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .notify      (notify),
    .notify_prio (notify_prio)
  );

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned LIRQ_W   = 10,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned ADDR_W   = 13
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            ev_valid,
  input logic [PRIO_W-1:0]               ev_prio,
  input logic [LIRQ_W-1:0]               ev_lirq,
  input logic                            mem_we,
  input logic [ADDR_W-1:0]               mem_addr,
  input logic [31:0]                     mem_wdata,
  input logic                            notify,
  input logic [PRIO_W-1:0]               notify_prio,
  input logic [NUM_PRIO-1:0]             post_hit,
  input logic [NUM_PRIO-1:0]             wrap_hit,
  input logic [NUM_PRIO-1:0][IDX_W-1:0]  idx_vec,
  input logic [NUM_PRIO-1:0]             gen_vec
);

  // R7
  write_follows_event_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> mem_we);

  // R7
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !mem_we);

  // R6
  notify_pairs_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we == notify && (!mem_we || notify_prio == mem_addr[ADDR_W-1 -: PRIO_W]));

  // R1
  payload_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> mem_wdata[30:0] == 31'($past(ev_lirq)));

  // R2
  queue_region_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> mem_addr[ADDR_W-1 -: PRIO_W] == $past(ev_prio));

  // R3
  single_queue_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(post_hit));

  for (genvar q = 0; q < NUM_PRIO; q++) begin : g_q
    // R3
    idle_queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !post_hit[q] |=> $stable(idx_vec[q]) && $stable(gen_vec[q]));

    // R4
    gen_flip_chk: assert property (@(posedge clk) disable iff (rst)
      wrap_hit[q] |=> gen_vec[q] != $past(gen_vec[q]) && idx_vec[q] == '0);

    // R4
    gen_keep_chk: assert property (@(posedge clk) disable iff (rst)
      post_hit[q] && !wrap_hit[q] |=> $stable(gen_vec[q]));
  end

endmodule

bind evq_writer evq_writer_chk #(
  .NUM_PRIO(NUM_PRIO), .IDX_W(IDX_W), .LIRQ_W(LIRQ_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_prio(ev_prio), .ev_lirq(ev_lirq),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .notify(notify), .notify_prio(notify_prio),
  .post_hit(post_hit), .wrap_hit(wrap_hit), .idx_vec(idx_vec), .gen_vec(gen_vec)
);

// File: tb/evq_writer_tb.sv
module evq_writer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_prio = '0;
  logic [9:0]  ev_lirq = '0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        notify;
  logic [2:0]  notify_prio;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evq_writer u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_prio(ev_prio), .ev_lirq(ev_lirq),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .notify(notify), .notify_prio(notify_prio)
  );

  typedef struct {
    logic [12:0] addr;
    logic [31:0] data;
    logic [2:0]  prio;
  } exp_t;

  exp_t        sb[$];
  int          m_idx[8];
  logic        m_gen[8];
  bit          done = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < 8; q++) begin
      m_idx[q] = 0;
      m_gen[q] = 1'b1;   // R5 restart state
    end
  endtask

  // Driver: present one event and push what must come out.
  task automatic post(input int prio, input int lirq);
    exp_t e;
    ev_valid = 1'b1;
    ev_prio  = 3'(prio);
    ev_lirq  = 10'(lirq);
    e.addr = {3'(prio), 10'(m_idx[prio])};
    e.data = {m_gen[prio], 21'd0, 10'(lirq)};
    e.prio = 3'(prio);
    sb.push_back(e);
    m_idx[prio] = m_idx[prio] + 1;
    if (m_idx[prio] == 1024) begin
      m_idx[prio] = 0;
      m_gen[prio] = ~m_gen[prio];   // R4 wrap rule
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    ev_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare each write.
  always @(negedge clk) begin
    if (rst) begin
      // R5 quiet outputs during reset
      if (mem_we !== 1'b0 || notify !== 1'b0) check("R5", "we/notify in reset", {mem_we, notify}, 0);
    end else begin
      check("R6", "notify matches write", 32'(notify), 32'(mem_we));
      if (mem_we === 1'b1) begin
        if (sb.size() == 0) begin
          check("R7", "write without event", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R1", "payload", {1'b0, mem_wdata[30:0]}, {1'b0, e.data[30:0]});
          check("R4", "generation flag", 32'(mem_wdata[31]), 32'(e.data[31]));
          check("R2", "address", 32'(mem_addr), 32'(e.addr));
          check("R6", "notify priority", 32'(notify_prio), 32'(e.prio));
        end
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R5", "mem_we in reset", 32'(mem_we), 0);
    rst = 1'b0;
    idle(2);

    // R5: every queue starts at slot 0 with flag 1
    for (int q = 0; q < 8; q++) post(q, 100 + q);
    idle(2);

    // R8: back-to-back posts, same and alternating queues
    for (int i = 0; i < 20; i++) post(i % 3, i * 7);
    for (int i = 0; i < 10; i++) post(6, 1023 - i);
    idle(1);

    // R3: sparse posts with gaps; other queues must not move
    for (int i = 0; i < 12; i++) begin
      post(7 - (i % 8), i);
      idle(i % 3);
    end

    // R4: two full laps of queue 5, interleaved with queue 2
    for (int i = 0; i < 2050; i++) begin
      post(5, i % 1024);
      if (i % 100 == 0) post(2, 555);
    end
    idle(3);

    // R5: reset in mid-run, then restart
    rst = 1'b1;
    ev_valid = 1'b0;
    model_reset();
    sb.delete();
    idle(3);
    rst = 1'b0;
    idle(1);
    post(5, 9);
    post(0, 1);
    post(5, 10);
    idle(4);

    // R7: no event, no write
    check("R7", "queue drained", 32'(sb.size()), 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule